// File: doc/BRIEF.md
# Ethernet Link Status Indicator Driver

This block drives five active-low indicator outputs for a 10/100 Mb/s Ethernet physical layer. Each indicator sits on one lane. The transmit lane shows transmit enable and the receive lane shows carrier sense. The link lane shows a link-good flag that is qualified elsewhere. The polarity lane shows receive polarity inversion, and the collision lane shows collisions. Every output is driven from a register, so each one changes one clock after its source.

Transmit and receive activity each pass through a retriggerable pulse stretcher that counts time-base ticks. A single-cycle frame therefore keeps its indicator lit for a visible time. With a 1 ms tick and the default of 50 ticks, that time is about 50 ms.

Two configuration bits reassign lanes. One bit switches the transmit lane to a connection-status flag. The other bit switches the polarity lane to full-duplex status. The collision lane is held dark whenever the link runs in full duplex.

Top module: `eth_led_ctrl`

## Requirements
- R1: While `rst_n` is low, every LED output is 1 (off), and both stretch counters are cleared.
- R2: With `tx_mode_conn` = 0, a cycle with `tx_en` = 1 drives `led_tx_n` to 0 at the next clock edge.
- R3: After the last cycle of activity, the stretched lane stays at 0 until STRETCH_TICKS ticks of `ms_tick` have been taken. The lane goes back to 1 at the clock edge that follows the edge on which the last tick was taken.
- R4: New activity while a lane is stretched restarts the full STRETCH_TICKS count.
- R5: `led_rx_n` follows `crs` with the same one-clock latency and the same stretching as R2 to R4.
- R6: With `tx_mode_conn` = 1, `led_tx_n` shows the inverse of `conn_stat` one clock later, and transmit activity has no effect. The pending transmit stretch count is cleared. After the bit returns to 0, the lane stays off until new `tx_en` activity.
- R7: `led_link_n` is the inverse of `link_ok`, delayed by one clock.
- R8: `led_pol_n` is the inverse of `pol_inv` one clock later when `pol_mode_fdx` = 0. It is the inverse of `fdx` when `pol_mode_fdx` = 1.
- R9: `led_col_n` is the inverse of `col`, unstretched and one clock later, when `fdx` = 0. It stays 1 whenever `fdx` = 1.
- R10: Each mode bit change takes effect on the clock edge that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| ms_tick | input | 1 | Clock enable of the stretch time base |
| tx_en | input | 1 | Transmit enable |
| crs | input | 1 | Carrier sense |
| link_ok | input | 1 | Qualified link-good flag |
| pol_inv | input | 1 | Receive polarity inverted |
| fdx | input | 1 | Full-duplex operation |
| col | input | 1 | Collision detected |
| conn_stat | input | 1 | Connection status flag |
| tx_mode_conn | input | 1 | 1: transmit lane shows `conn_stat` |
| pol_mode_fdx | input | 1 | 1: polarity lane shows `fdx` |
| led_tx_n | output | 1 | Transmit / connection indicator, active low |
| led_rx_n | output | 1 | Receive indicator, active low |
| led_link_n | output | 1 | Link indicator, active low |
| led_pol_n | output | 1 | Polarity / duplex indicator, active low |
| led_col_n | output | 1 | Collision indicator, active low |

## Verification
The checker tests the one-clock relations on every cycle. These cover the unstretched lanes, the mode routing, collision blanking in full duplex, the off state during reset, and the immediate lighting that activity causes. The length of the stretch window depends on the tick history, so only the bench's reference model and its directed scenarios can show it. The same holds for retriggering and for the clearing of a pending count after the transmit lane is switched away.

// File: rtl/led_pkg.sv
package led_pkg;
  localparam int LANES = 5;
  localparam int STRETCHED = 2;

  typedef enum logic [2:0] {
    LANE_TX   = 3'd0,
    LANE_RX   = 3'd1,
    LANE_LINK = 3'd2,
    LANE_POL  = 3'd3,
    LANE_COL  = 3'd4
  } lane_e;
endpackage

// File: rtl/led_stretch.sv
// Retriggerable stretcher: activity reloads the count, and ticks count it down.
module led_stretch #(
  parameter int TICKS = 50,
  localparam int W = $clog2(TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic act,
  input  logic clr,
  output logic lit
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (act)
      cnt_d = W'(TICKS);
    else if (tick && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign lit = !clr && (act || (cnt_q != '0));
endmodule

// File: rtl/led_route.sv
// Chooses the source of each lane from the mode bits.
module led_route
  import led_pkg::*;
(
  input  logic             tx_lit,
  input  logic             rx_lit,
  input  logic             link_ok,
  input  logic             pol_inv,
  input  logic             fdx,
  input  logic             col,
  input  logic             conn_stat,
  input  logic             tx_mode_conn,
  input  logic             pol_mode_fdx,
  output logic [LANES-1:0] on
);
  always_comb begin
    on            = '0;
    on[LANE_TX]   = tx_mode_conn ? conn_stat : tx_lit;
    on[LANE_RX]   = rx_lit;
    on[LANE_LINK] = link_ok;
    on[LANE_POL]  = pol_mode_fdx ? fdx : pol_inv;
    on[LANE_COL]  = col && !fdx;
  end
endmodule

// File: rtl/led_drive.sv
// Output register stage that inverts to active-low.
module led_drive #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] on,
  output logic [N-1:0] led_n
);
  logic [N-1:0] led_d;

  always_comb led_d = ~on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      led_n <= '1;
    else
      led_n <= led_d;
  end
endmodule

// File: rtl/eth_led_ctrl.sv
module eth_led_ctrl
  import led_pkg::*;
#(
  parameter int STRETCH_TICKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic tx_en,
  input  logic crs,
  input  logic link_ok,
  input  logic pol_inv,
  input  logic fdx,
  input  logic col,
  input  logic conn_stat,
  input  logic tx_mode_conn,
  input  logic pol_mode_fdx,
  output logic led_tx_n,
  output logic led_rx_n,
  output logic led_link_n,
  output logic led_pol_n,
  output logic led_col_n
);
  logic [STRETCHED-1:0] act_v, clr_v, lit_v;
  logic [LANES-1:0]     on_v, led_v;

  assign act_v = {crs, tx_en};
  assign clr_v = {1'b0, tx_mode_conn};

  for (genvar g = 0; g < STRETCHED; g++) begin : g_str
    led_stretch #(.TICKS(STRETCH_TICKS)) u_str (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (ms_tick),
      .act  (act_v[g]),
      .clr  (clr_v[g]),
      .lit  (lit_v[g])
    );
  end

  led_route u_route (
    .tx_lit      (lit_v[0]),
    .rx_lit      (lit_v[1]),
    .link_ok     (link_ok),
    .pol_inv     (pol_inv),
    .fdx         (fdx),
    .col         (col),
    .conn_stat   (conn_stat),
    .tx_mode_conn(tx_mode_conn),
    .pol_mode_fdx(pol_mode_fdx),
    .on          (on_v)
  );

  led_drive #(.N(LANES)) u_drive (
    .clk  (clk),
    .rst_n(rst_n),
    .on   (on_v),
    .led_n(led_v)
  );

  assign led_tx_n   = led_v[LANE_TX];
  assign led_rx_n   = led_v[LANE_RX];
  assign led_link_n = led_v[LANE_LINK];
  assign led_pol_n  = led_v[LANE_POL];
  assign led_col_n  = led_v[LANE_COL];
endmodule

// File: rtl/eth_led_ctrl_chk.sv
module eth_led_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic crs,
  input logic link_ok,
  input logic pol_inv,
  input logic fdx,
  input logic col,
  input logic conn_stat,
  input logic tx_mode_conn,
  input logic pol_mode_fdx,
  input logic led_tx_n,
  input logic led_rx_n,
  input logic led_link_n,
  input logic led_pol_n,
  input logic led_col_n
);
  // R1
  reset_dark_chk: assert property (@(posedge clk)
    !rst_n |=> (led_tx_n && led_rx_n && led_link_n && led_pol_n && led_col_n));

  // R2
  tx_light_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !tx_mode_conn) |=> !led_tx_n);

  // R5
  rx_light_chk: assert property (@(posedge clk) disable iff (!rst_n)
    crs |=> !led_rx_n);

  // R6
  tx_conn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mode_conn |=> (led_tx_n == !$past(conn_stat)));

  // R7
  link_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (led_link_n == !$past(link_ok)));

  // R8
  pol_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pol_mode_fdx |=> (led_pol_n == !$past(pol_inv)));

  // R10
  pol_fdx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pol_mode_fdx |=> (led_pol_n == !$past(fdx)));

  // R9
  col_fdx_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fdx |=> led_col_n);

  // R9
  col_hdx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fdx |=> (led_col_n == !$past(col)));
endmodule

bind eth_led_ctrl eth_led_ctrl_chk u_chk (.*);

// File: tb/eth_led_ctrl_tb.sv
`timescale 1ns/1ps
module eth_led_ctrl_tb;
  localparam int HOLD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick;
  logic tx_en = 0, crs = 0, link_ok = 0, pol_inv = 0, fdx = 0, col = 0;
  logic conn_stat = 0, tx_mode_conn = 0, pol_mode_fdx = 0;
  logic led_tx_n, led_rx_n, led_link_n, led_pol_n, led_col_n;

  int total = 0, bad = 0;
  int tick_ctr = 0;
  int txc = 0, rxc = 0;
  logic e_tx = 1, e_rx = 1, e_link = 1, e_pol = 1, e_col = 1;
  bit compare_on = 0;

  always #10 clk = ~clk;

  eth_led_ctrl #(.STRETCH_TICKS(HOLD)) u_dut (.*);

  // tick every fourth clock
  always @(posedge clk) tick_ctr <= (tick_ctr + 1) % 4;
  assign ms_tick = (tick_ctr == 3);

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txc = 0; rxc = 0;
      e_tx = 1; e_rx = 1; e_link = 1; e_pol = 1; e_col = 1;
    end else begin
      e_tx   = tx_mode_conn ? !conn_stat : !(tx_en || txc > 0);
      e_rx   = !(crs || rxc > 0);
      e_link = !link_ok;
      e_pol  = pol_mode_fdx ? !fdx : !pol_inv;
      e_col  = fdx ? 1'b1 : !col;
      if (tx_mode_conn) txc = 0;
      else if (tx_en) txc = HOLD;
      else if (ms_tick && txc > 0) txc = txc - 1;
      if (crs) rxc = HOLD;
      else if (ms_tick && rxc > 0) rxc = rxc - 1;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (compare_on) begin
    check("R3", led_tx_n, e_tx);
    check("R5", led_rx_n, e_rx);
    check("R7", led_link_n, e_link);
    check("R8", led_pol_n, e_pol);
    check("R9", led_col_n, e_col);
  end

  task automatic wait_ticks(input int n);
    int c = 0;
    while (c < n) begin
      @(negedge clk);
      if (ms_tick) c++;
    end
    @(negedge clk);
  endtask

  task automatic tx_pulse();
    @(negedge clk); tx_en = 1;
    @(negedge clk); tx_en = 0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: all dark in reset
    check("R1", led_tx_n & led_rx_n & led_link_n & led_pol_n & led_col_n, 1'b1);
    rst_n = 1;
    compare_on = 1;
    repeat (3) @(negedge clk);

    // R2: a single-cycle transmit pulse lights the lane
    @(negedge clk); tx_en = 1;
    @(negedge clk); tx_en = 0;
    check("R2", led_tx_n, 1'b0);
    wait_ticks(HOLD + 1);
    check("R3", led_tx_n, 1'b1);

    // R4: retrigger, then R3 boundary
    tx_pulse();
    wait_ticks(2);
    tx_pulse();
    wait_ticks(4);
    check("R4", led_tx_n, 1'b0);
    wait_ticks(1);
    check("R3", led_tx_n, 1'b0);
    @(negedge clk);
    check("R3", led_tx_n, 1'b1);

    // R6: switching away clears the pending count
    tx_pulse();
    tx_mode_conn = 1; conn_stat = 0; tx_en = 1;
    @(negedge clk);
    check("R6", led_tx_n, 1'b1);
    conn_stat = 1; tx_en = 0;
    @(negedge clk);
    check("R10", led_tx_n, 1'b0);
    tx_mode_conn = 0;
    @(negedge clk);
    check("R6", led_tx_n, 1'b1);

    // R9 and R10 directed
    col = 1; fdx = 0;
    @(negedge clk);
    check("R9", led_col_n, 1'b0);
    fdx = 1;
    @(negedge clk);
    check("R9", led_col_n, 1'b1);
    pol_mode_fdx = 1; pol_inv = 0;
    @(negedge clk);
    check("R10", led_pol_n, 1'b0);
    col = 0; fdx = 0; pol_mode_fdx = 0;

    // mixed traffic against the reference
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      tx_en        = ($urandom % 16) == 0;
      crs          = ($urandom % 20) == 0;
      link_ok      = ($urandom % 8) != 0;
      pol_inv      = ($urandom % 6) == 0;
      col          = ($urandom % 5) == 0;
      conn_stat    = ($urandom % 2) == 1;
      if ((i % 97) == 0) fdx = ~fdx;
      if ((i % 151) == 0) tx_mode_conn = ~tx_mode_conn;
      if ((i % 211) == 0) pol_mode_fdx = ~pol_mode_fdx;
    end

    // R1: reset mid-traffic
    tx_en = 1; crs = 1; link_ok = 1; col = 1; fdx = 0;
    @(negedge clk);
    compare_on = 0;
    rst_n = 0;
    #1;
    check("R1", led_tx_n & led_rx_n & led_link_n & led_pol_n & led_col_n, 1'b1);
    tx_en = 0; crs = 0;
    @(negedge clk); rst_n = 1; compare_on = 1;
    @(negedge clk);
    check("R1", led_rx_n, 1'b1);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule